// File: doc/BRIEF.md
# Triggered Sample Capture Buffer

This block is a test acquisition channel for a stream of digitised samples, one per clock. Every sample first runs through a delay line whose length the host sets in clock cycles, so that a trigger arriving some fixed time after the event of interest stores the sample that belongs to that event rather than the one present when the trigger lands.

On each accepted trigger the delayed stream is written into a run memory at the next free address. In single mode a trigger stores one sample. In temporal mode it stores a burst of consecutive delayed samples whose length the host sets between 1 and 32. A trigger that lands while a burst is still being written is dropped and counted. The run fills the memory and then stops with a full flag raised; a burst that runs past the last address is cut short. The host then reads the stored samples by address through a registered read port and pulses a clear input to empty the buffer and start the next run.

Top module: `trig_capture_buffer`

## Requirements
- R1: After reset, fill_count is 0, run_full is 0, busy is 0 and missed_count is 0.
- R2: With cfg_latency = L (1 to 255), a capture at a clock edge stores the sample_in value that was present at the edge L cycles earlier.
- R3: With cfg_temporal = 0, each accepted trigger stores exactly one sample at address fill_count and raises fill_count by one; busy stays 0; addresses fill upward from 0.
- R4: With cfg_temporal = 1, an accepted trigger stores N consecutive delayed samples at consecutive addresses, on the trigger edge and the N-1 edges after it, where N is cfg_burst_len limited to the range 1 to 32 (0 gives 1, values above 32 give 32); busy is 1 from the edge after the trigger until the last sample of the burst is written.
- R5: A trigger that arrives while busy is 1 stores nothing beyond the running burst and raises missed_count by one.
- R6: When fill_count reaches 1024, run_full becomes 1, any unfinished burst is cut off, busy returns to 0, and later triggers leave fill_count and missed_count unchanged until a clear.
- R7: rd_data shows the word stored at rd_addr one clock edge after rd_addr is presented.
- R8: A clear pulse sets fill_count, missed_count, busy and run_full to 0 on the next edge so the next run starts at address 0; a trigger on the same edge as the clear is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_in | input | 10 | Incoming sample, one per clock |
| trig_in | input | 1 | Trigger request, sampled each edge |
| cfg_temporal | input | 1 | 0 = single mode, 1 = temporal (burst) mode |
| cfg_burst_len | input | 6 | Burst length in temporal mode, limited to 1..32 |
| cfg_latency | input | 8 | Trigger latency in clock cycles |
| clear | input | 1 | Pulse: empty the buffer and start a new run |
| rd_addr | input | 10 | Host read address |
| rd_data | output | 10 | Stored word at rd_addr, one cycle later |
| busy | output | 1 | A temporal burst is still being written |
| run_full | output | 1 | Run memory is full, capture stopped |
| fill_count | output | 11 | Number of samples stored in this run |
| missed_count | output | 16 | Triggers dropped during a burst |

## Verification
The hardest state to reach is a burst that starts a few words before the end of memory and must be truncated exactly at address 1023. The stimulus first stores five single samples so the burst boundaries fall off alignment, then repeats full-length bursts until one straddles the end, so the last burst writes only 27 of its 32 words. A dropped trigger is also placed inside the very first burst, and the full readback then shows both that no stray word was written and that the truncated burst holds the right delayed samples.

// File: rtl/tcb_pkg.sv
// Shared types for the triggered sample capture buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package tcb_pkg;
    // capture mode selected by the host
    typedef enum logic {
        CAP_SINGLE   = 1'b0,
        CAP_TEMPORAL = 1'b1
    } cap_mode_e;
endpackage

// File: rtl/tcb_delay_line.sv
// Programmable delay line for the sample stream.
// Writes every incoming sample into a circular buffer and reads the entry
// written LAT edges ago. Assumes latency >= 1; latency 0 yields the entry
// written one full ring earlier.
module tcb_delay_line #(
    parameter int DATA_W = 10,
    parameter int LAT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [LAT_W-1:0]  latency,
    output logic [DATA_W-1:0] dout
);
    localparam int RING = 2 ** LAT_W;

    logic [DATA_W-1:0] ring [RING];
    logic [LAT_W-1:0]  wp;
    logic [LAT_W-1:0]  rp;

    // advance the write pointer once per clock
    always_ff @(posedge clk) begin
        if (!rst_n) wp <= '0;
        else        wp <= wp + 1'b1;
    end

    // store the current sample at the write pointer
    always_ff @(posedge clk) begin
        ring[wp] <= din;
    end

    // read pointer trails the write pointer by the latency
    always_comb begin
        rp   = wp - latency;
        dout = ring[rp];
    end
endmodule

// File: rtl/tcb_capture_ctrl.sv
// Capture controller: decides on which edges a delayed sample is written,
// tracks the write address, burst progress, full flag and dropped triggers.
// Assumes DEPTH is a power of two and BURST_MAX >= 1.
module tcb_capture_ctrl
    import tcb_pkg::*;
#(
    parameter int DEPTH     = 1024,
    parameter int BURST_MAX = 32,
    parameter int LEN_W     = 6,
    parameter int MISS_W    = 16,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int REM_W    = $clog2(BURST_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  cap_mode_e         mode,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic              clear,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   fill,
    output logic              full,
    output logic              busy,
    output logic [MISS_W-1:0] missed
);
    logic [REM_W-1:0] remain;
    logic [REM_W-1:0] first_rem;

    // limit the requested burst length to 1..BURST_MAX
    function automatic logic [REM_W-1:0] clamp_len(input logic [LEN_W-1:0] len);
        if (len == '0)                          return REM_W'(1);
        else if (int'(len) > BURST_MAX)         return REM_W'(BURST_MAX);
        else                                    return REM_W'(len);
    endfunction

    // extra edges a new trigger will write after its own edge
    always_comb begin
        if (mode == CAP_TEMPORAL) first_rem = clamp_len(burst_len) - 1'b1;
        else                      first_rem = '0;
    end

    // write on a trigger or while a burst is running, unless stopped
    always_comb begin
        wr_en   = !clear && !full && (trig || (remain != '0));
        wr_addr = fill[ADDR_W-1:0];
        busy    = (remain != '0);
    end

    // address, burst and full-flag bookkeeping for the run
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fill   <= '0;
            full   <= 1'b0;
            remain <= '0;
        end else if (wr_en) begin
            fill <= fill + 1'b1;
            if (fill == (ADDR_W+1)'(DEPTH - 1)) begin
                full   <= 1'b1;
                remain <= '0;
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end else begin
                remain <= first_rem;
            end
        end
    end

    // count triggers that land inside a running burst
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            missed <= '0;
        else if (trig && (remain != '0) && !full)
            missed <= missed + 1'b1;
    end
endmodule

// File: rtl/tcb_run_mem.sv
// Run memory: one write port from the capture path, one registered read
// port for the host. Assumes a single clock for both ports.
module tcb_run_mem #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // store captured samples
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // registered host read
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/trig_capture_buffer.sv
// Triggered sample capture buffer, top level.
// Delays the sample stream by a programmable latency, writes it into a run
// memory on triggers (single or burst), stops at full, and lets the host
// read by address and clear for the next run.
// Assumes configuration inputs are held steady while a burst is running.
module trig_capture_buffer
    import tcb_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int DEPTH     = 1024,
    parameter int BURST_MAX = 32,
    parameter int LAT_W     = 8,
    parameter int LEN_W     = 6,
    parameter int MISS_W    = 16,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              trig_in,
    input  logic              cfg_temporal,
    input  logic [LEN_W-1:0]  cfg_burst_len,
    input  logic [LAT_W-1:0]  cfg_latency,
    input  logic              clear,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              run_full,
    output logic [ADDR_W:0]   fill_count,
    output logic [MISS_W-1:0] missed_count
);
    logic [DATA_W-1:0] delayed;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    cap_mode_e         mode;

    // decode the mode input into the shared type
    always_comb mode = cap_mode_e'(cfg_temporal);

    tcb_delay_line #(
        .DATA_W (DATA_W),
        .LAT_W  (LAT_W)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (sample_in),
        .latency (cfg_latency),
        .dout    (delayed)
    );

    tcb_capture_ctrl #(
        .DEPTH     (DEPTH),
        .BURST_MAX (BURST_MAX),
        .LEN_W     (LEN_W),
        .MISS_W    (MISS_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig_in),
        .mode      (mode),
        .burst_len (cfg_burst_len),
        .clear     (clear),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .fill      (fill_count),
        .full      (run_full),
        .busy      (busy),
        .missed    (missed_count)
    );

    tcb_run_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (delayed),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/tcb_checker.sv
// Property checker for the capture buffer, attached to the top by bind.
// Assumes the top's port names and FILL_W = log2(DEPTH) + 1.
module tcb_checker #(
    parameter int DEPTH  = 1024,
    parameter int FILL_W = 11,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_in,
    input logic              cfg_temporal,
    input logic              clear,
    input logic              busy,
    input logic              run_full,
    input logic [FILL_W-1:0] fill_count,
    input logic [MISS_W-1:0] missed_count
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (fill_count == '0 && !run_full && !busy && missed_count == '0));

    // R6
    full_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_full |-> (fill_count == FILL_W'(DEPTH) && !busy));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_full && !clear) |=> (run_full && $stable(fill_count) && $stable(missed_count)));

    // R5
    missed_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig_in && !run_full && !clear)
            |=> (missed_count == MISS_W'($past(missed_count) + 1'b1)));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill_count == '0 && !run_full && !busy && missed_count == '0));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_temporal && !busy && trig_in && !run_full && !clear)
            |=> (fill_count == FILL_W'($past(fill_count) + 1'b1) && !busy));

    // R4
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (fill_count == $past(fill_count)
                    || fill_count == FILL_W'($past(fill_count) + 1'b1)));
endmodule

bind trig_capture_buffer tcb_checker #(
    .DEPTH  (DEPTH),
    .FILL_W (ADDR_W + 1),
    .MISS_W (MISS_W)
) u_tcb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_in      (trig_in),
    .cfg_temporal (cfg_temporal),
    .clear        (clear),
    .busy         (busy),
    .run_full     (run_full),
    .fill_count   (fill_count),
    .missed_count (missed_count)
);

// File: tb/test_trig_capture_buffer.sv
// Scoreboard bench: the driver task models each capture from the
// requirements and queues the expected word; the monitor pops and compares
// during readback.
module test_trig_capture_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  sample_in = '0;
    logic        trig_in = 1'b0;
    logic        cfg_temporal = 1'b0;
    logic [5:0]  cfg_burst_len = 6'd1;
    logic [7:0]  cfg_latency = 8'd5;
    logic        clear = 1'b0;
    logic [9:0]  rd_addr = '0;
    logic [9:0]  rd_data;
    logic        busy;
    logic        run_full;
    logic [10:0] fill_count;
    logic [15:0] missed_count;

    int checks = 0;
    int fails  = 0;
    int edge_cnt = 0;

    int m_wa = 0, m_rem = 0, m_missed = 0;
    bit m_full = 0;
    logic [9:0] exp_q[$];

    logic rd_go = 1'b0, rd_go_q = 1'b0;
    logic [9:0] rd_addr_q = '0;

    trig_capture_buffer i_trig_capture_buffer (
        .clk, .rst_n, .sample_in, .trig_in, .cfg_temporal, .cfg_burst_len,
        .cfg_latency, .clear, .rd_addr, .rd_data, .busy, .run_full,
        .fill_count, .missed_count
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [9:0] smp(input int k);
        return 10'((k * 37 + 11) & 10'h3ff);
    endfunction

    always @(posedge clk) edge_cnt <= edge_cnt + 1;
    always @(negedge clk) sample_in <= smp(edge_cnt);

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic int clamp(input int len);
        if (len == 0) return 1;
        if (len > 32) return 32;
        return len;
    endfunction

    // driver: one cycle of stimulus plus the expected-result model
    task automatic step(input bit trig, input bit clr = 0);
        int k;
        bit cap;
        @(negedge clk);
        trig_in = trig;
        clear   = clr;
        k = edge_cnt;
        cap = 0;
        if (clr) begin
            m_wa = 0; m_rem = 0; m_missed = 0; m_full = 0;
            exp_q.delete();
        end else if (!m_full) begin
            if (m_rem > 0) begin
                cap = 1;
                m_rem--;
                if (trig) m_missed++;
            end else if (trig) begin
                cap = 1;
                m_rem = cfg_temporal ? clamp(int'(cfg_burst_len)) - 1 : 0;
            end
            if (cap) begin
                exp_q.push_back(smp(k - int'(cfg_latency)));
                m_wa++;
                if (m_wa == DEPTH) begin m_full = 1; m_rem = 0; end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0);
    endtask

    // monitor: compare each registered read with the queued expectation
    always @(posedge clk) begin
        rd_go_q   <= rd_go;
        rd_addr_q <= rd_addr;
    end
    always @(negedge clk) begin
        if (rd_go_q) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7 readback with empty scoreboard", int'(rd_data), -1);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, $sformatf("R2/R7 word at %0d", rd_addr_q),
                    int'(rd_data), int'(e));
            end
        end
    end

    task automatic read_range(input int n);
        for (int a = 0; a < n; a++) begin
            @(negedge clk);
            trig_in = 0;
            rd_addr = 10'(a);
            rd_go   = 1'b1;
        end
        @(negedge clk);
        rd_go = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", edge_cnt, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fill_count == 0, "R1 fill_count", int'(fill_count), 0);
        chk(!run_full && !busy, "R1 full/busy", int'({run_full, busy}), 0);
        chk(missed_count == 0, "R1 missed_count", int'(missed_count), 0);

        // R2/R3 single mode, latency 5
        cfg_latency = 8'd5; cfg_temporal = 1'b0;
        idle(40);
        for (int i = 0; i < 5; i++) begin step(1); idle(3); end
        chk(fill_count == 11'(m_wa), "R3 fill after singles", int'(fill_count), m_wa);
        chk(!busy, "R3 busy stays low", int'(busy), 0);

        // R4 temporal, length 40 limited to 32, with a dropped trigger (R5)
        cfg_temporal = 1'b1; cfg_burst_len = 6'd40;
        step(1);
        step(0);
        chk(busy, "R4 busy during burst", int'(busy), 1);
        idle(8);
        step(1);
        idle(30);
        chk(!busy, "R4 busy clears after burst", int'(busy), 0);
        chk(fill_count == 11'(m_wa), "R4 fill after 32-word burst", int'(fill_count), m_wa);
        chk(missed_count == 16'(m_missed), "R5 missed_count", int'(missed_count), m_missed);

        // R6 fill up to full with truncation of the last burst
        cfg_burst_len = 6'd32;
        while (!m_full) begin step(1); idle(36); end
        chk(run_full, "R6 run_full", int'(run_full), 1);
        chk(fill_count == 11'(DEPTH), "R6 fill at full", int'(fill_count), DEPTH);
        step(1); idle(3);
        chk(fill_count == 11'(DEPTH), "R6 trigger after full ignored", int'(fill_count), DEPTH);
        chk(missed_count == 16'(m_missed), "R6 missed unchanged when full",
            int'(missed_count), m_missed);
        read_range(DEPTH);
        chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

        // R8 clear starts a new run
        step(0, 1);
        step(0);
        chk(fill_count == 0 && !run_full, "R8 clear empties run", int'(fill_count), 0);
        chk(missed_count == 0 && !busy, "R8 clear resets counters", int'(missed_count), 0);

        // R2 long latency, R4 length 0 acts as 1, short burst of 3
        cfg_latency = 8'd200; cfg_temporal = 1'b0;
        idle(5);
        step(1); idle(2); step(1); idle(2);
        cfg_temporal = 1'b1; cfg_burst_len = 6'd0;
        step(1); step(0);
        chk(!busy, "R4 length 0 gives one word", int'(busy), 0);
        idle(2);
        cfg_burst_len = 6'd3;
        step(1); idle(5);
        chk(fill_count == 11'(m_wa), "R4 fill after short burst", int'(fill_count), m_wa);
        read_range(m_wa);

        // R8 clear wins over a trigger on the same edge
        step(1, 1);
        step(0);
        chk(fill_count == 0, "R8 trigger with clear not stored", int'(fill_count), 0);
        idle(2);
        finish_run();
    end
endmodule